// File: doc/BRIEF.md
# Integer ALU with Condition Flag Generation

This block is the combinational arithmetic and logic unit of a compact 16-bit-encoded processor core. It receives two 32-bit register operands, an 8-bit immediate, the current carry flag and a 4-bit operation select. In the same cycle it returns the operation result, a write-enable telling the register file whether to keep that result, and fresh N, Z, C and V flag values. A per-flag update mask tells the status register which of those four flags to load.

Arithmetic operations share one adder. It covers add, subtract, add-with-carry, subtract-with-carry, negate, compare and compare-negative. The remaining operations go through a logic path: AND, XOR, OR, bit-clear, move-not, the low half of a multiply and move of a zero-extended immediate. Each operation class loads its own subset of the flags. Compare-style operations update flags only and never request a register write.

Top module: `alu32_core`

## Requirements
- R1: Whenever the N flag is in the update mask it equals bit 31 of `result`. Whenever Z is in the mask it is 1 exactly when `result` is zero. `result` carries the computed value even when `result_we` is 0.
- R2: Add (select 0) and compare-negative (select 6) compute A+B and ignore `carry_in`. C is the unsigned carry out of bit 31 and V is signed overflow. All four flags are updated.
- R3: Subtract (select 1), compare (select 5) and negate (select 4, computing 0-B and ignoring A) set C to 1 exactly when the minuend is unsigned greater than or equal to the subtrahend. V is signed overflow of the subtraction. All four flags are updated.
- R4: Add-with-carry (select 2) computes A+B+`carry_in`. C is the carry out and V is the overflow taken with B as the second operand.
- R5: Subtract-with-carry (select 3) first forms B' = B + NOT `carry_in` modulo 2^32. It then computes A-B' and derives C and V from A, B' and the result.
- R6: Compare (5), compare-negative (6) and test (7, the AND of A and B) hold `result_we` at 0. Test updates N and Z only.
- R7: AND (8), XOR (9), OR (10), bit-clear A AND NOT B (11) and move-not NOT B (12) write the result and update N and Z only.
- R8: Multiply (13) writes the low 32 bits of A*B. Move-immediate (14) writes `imm8` zero-extended to 32 bits. Both update N and Z only.
- R9: Select 15 is undefined. It gives a zero result, `result_we` = 0 and an all-zero update mask.
- R10: `flag_upd` is ordered {N,Z,C,V} from bit 3 down to bit 0. A flag whose mask bit is 0 is driven as follows: C repeats `carry_in`, and N, Z and V are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation select, encoded as listed in the requirements |
| opnd_a | input | 32 | First operand (minuend, augend) |
| opnd_b | input | 32 | Second operand |
| imm8 | input | 8 | Immediate for move-immediate |
| carry_in | input | 1 | Current C flag |
| result | output | 32 | Operation result |
| result_we | output | 1 | Result should be written to the destination |
| flag_n | output | 1 | New N flag |
| flag_z | output | 1 | New Z flag |
| flag_c | output | 1 | New C flag |
| flag_v | output | 1 | New V flag |
| flag_upd | output | 4 | Flag update mask {N,Z,C,V} |

## Verification
The block holds no state. A wrong decode entry or adder input therefore shows on the ports within the same evaluation as the stimulus. It appears as a wrong mask bit, a spurious write-enable, or a C or V value that disagrees with an unsigned or signed comparison of the operands. The subtract-with-carry fold is exercised where B' wraps to zero and where it pushes the subtraction into overflow. Those are the two places where deriving flags from B instead of B' gives a different C or V. Operand values at the 0x7FFFFFFF/0x80000000 and all-ones boundaries separate carry from overflow in every arithmetic class.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

   typedef enum logic [3:0] {
      ALU_ADD  = 4'd0,
      ALU_SUB  = 4'd1,
      ALU_ADC  = 4'd2,
      ALU_SBC  = 4'd3,
      ALU_NEG  = 4'd4,
      ALU_CMP  = 4'd5,
      ALU_CMN  = 4'd6,
      ALU_TST  = 4'd7,
      ALU_AND  = 4'd8,
      ALU_XOR  = 4'd9,
      ALU_OR   = 4'd10,
      ALU_BIC  = 4'd11,
      ALU_NOT  = 4'd12,
      ALU_MUL  = 4'd13,
      ALU_MOVI = 4'd14,
      ALU_RSVD = 4'd15
   } alu_op_e;

   typedef enum logic [2:0] {
      LS_AND = 3'd0,
      LS_XOR = 3'd1,
      LS_OR  = 3'd2,
      LS_BIC = 3'd3,
      LS_NOT = 3'd4,
      LS_MUL = 3'd5,
      LS_IMM = 3'd6
   } logic_sel_e;

   // mask bit positions, status register decodes this order
   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_C = 1;
   localparam int FLG_V = 0;

   localparam logic [3:0] MASK_ALL = 4'b1111;
   localparam logic [3:0] MASK_NZ  = 4'b1100;

   typedef struct packed {
      logic       use_adder;
      logic       use_logic;
      logic       sub;
      logic       carry_chain;
      logic       fold_borrow;
      logic       zero_a;
      logic       wr;
      logic [3:0] mask;
      logic_sel_e lsel;
   } alu_ctl_t;

endpackage

// File: rtl/alu32_dec.sv
module alu32_dec
   import alu32_pkg::*;
#(
   parameter bit USE_MUL = 1'b1
) (
   input  alu_op_e  op,
   output alu_ctl_t ctl
);

   always_comb begin
      ctl = '0;
      unique case (op)
         ALU_ADD, ALU_CMN, ALU_ADC: begin
            ctl.use_adder   = 1'b1;
            ctl.carry_chain = (op == ALU_ADC);
            ctl.wr          = (op != ALU_CMN);
            ctl.mask        = MASK_ALL;
         end
         ALU_SUB, ALU_CMP, ALU_SBC, ALU_NEG: begin
            ctl.use_adder   = 1'b1;
            ctl.sub         = 1'b1;
            ctl.fold_borrow = (op == ALU_SBC);
            ctl.zero_a      = (op == ALU_NEG);
            ctl.wr          = (op != ALU_CMP);
            ctl.mask        = MASK_ALL;
         end
         ALU_TST: begin
            ctl.use_logic = 1'b1;
            ctl.lsel      = LS_AND;
            ctl.mask      = MASK_NZ;
         end
         ALU_AND, ALU_XOR, ALU_OR, ALU_BIC, ALU_NOT, ALU_MOVI: begin
            ctl.use_logic = 1'b1;
            ctl.wr        = 1'b1;
            ctl.mask      = MASK_NZ;
            case (op)
               ALU_AND: ctl.lsel = LS_AND;
               ALU_XOR: ctl.lsel = LS_XOR;
               ALU_OR:  ctl.lsel = LS_OR;
               ALU_BIC: ctl.lsel = LS_BIC;
               ALU_NOT: ctl.lsel = LS_NOT;
               default: ctl.lsel = LS_IMM;
            endcase
         end
         ALU_MUL: begin
            if (USE_MUL) begin
               ctl.use_logic = 1'b1;
               ctl.wr        = 1'b1;
               ctl.mask      = MASK_NZ;
               ctl.lsel      = LS_MUL;
            end
         end
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              carry_flag,
   input  logic              sub,
   input  logic              carry_chain,
   input  logic              fold_borrow,
   input  logic              zero_a,
   output logic [DATA_W-1:0] sum,
   output logic              c_out,
   output logic              v_out
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] x_op;
   logic [DATA_W-1:0] b_fold;
   logic [DATA_W-1:0] y_op;
   logic              c_lsb;
   logic [DATA_W:0]   wide;

   always_comb begin
      x_op   = zero_a ? '0 : a;
      // subtract-with-carry: borrow joins the subtrahend before flags
      b_fold = fold_borrow ? (b + {{(DATA_W-1){1'b0}}, ~carry_flag}) : b;
      y_op   = sub ? ~b_fold : b_fold;
      c_lsb  = sub | (carry_chain & carry_flag);
      wide   = {1'b0, x_op} + {1'b0, y_op} + {{DATA_W{1'b0}}, c_lsb};
      sum    = wide[DATA_W-1:0];
      c_out  = wide[DATA_W];
      v_out  = (x_op[MSB] == y_op[MSB]) && (sum[MSB] != x_op[MSB]);
   end

endmodule

// File: rtl/alu32_logic.sv
module alu32_logic
   import alu32_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 8,
   parameter bit USE_MUL = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [IMM_W-1:0]  imm,
   input  logic_sel_e        lsel,
   output logic [DATA_W-1:0] y
);

   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] prod;
   logic [DATA_W-1:0] imm_ext;

   generate
      if (USE_MUL) begin : g_mul
         assign prod = a * b;
      end else begin : g_nomul
         assign prod = '0;
      end
      if (PAD_W > 0) begin : g_pad
         assign imm_ext = {{PAD_W{1'b0}}, imm};
      end else begin : g_nopad
         assign imm_ext = imm[DATA_W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (lsel)
         LS_AND:  y = a & b;
         LS_XOR:  y = a ^ b;
         LS_OR:   y = a | b;
         LS_BIC:  y = a & ~b;
         LS_NOT:  y = ~b;
         LS_MUL:  y = prod;
         LS_IMM:  y = imm_ext;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/alu32_core.sv
module alu32_core
   import alu32_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 8,
   parameter bit USE_MUL = 1'b1
) (
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [IMM_W-1:0]  imm8,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              result_we,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v,
   output logic [3:0]        flag_upd
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("alu32_core: DATA_W must be at least 2");
      end
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
         $error("alu32_core: IMM_W must lie in 1..DATA_W");
      end
   endgenerate

   alu_ctl_t          ctl;
   logic [DATA_W-1:0] add_y;
   logic              add_c;
   logic              add_v;
   logic [DATA_W-1:0] log_y;

   alu32_dec #(.USE_MUL(USE_MUL)) dec_i (
      .op  (alu_op_e'(op_sel)),
      .ctl (ctl)
   );

   alu32_addsub #(.DATA_W(DATA_W)) add_i (
      .a           (opnd_a),
      .b           (opnd_b),
      .carry_flag  (carry_in),
      .sub         (ctl.sub),
      .carry_chain (ctl.carry_chain),
      .fold_borrow (ctl.fold_borrow),
      .zero_a      (ctl.zero_a),
      .sum         (add_y),
      .c_out       (add_c),
      .v_out       (add_v)
   );

   alu32_logic #(.DATA_W(DATA_W), .IMM_W(IMM_W), .USE_MUL(USE_MUL)) log_i (
      .a    (opnd_a),
      .b    (opnd_b),
      .imm  (imm8),
      .lsel (ctl.lsel),
      .y    (log_y)
   );

   always_comb begin
      if (ctl.use_adder)      result = add_y;
      else if (ctl.use_logic) result = log_y;
      else                    result = '0;
      result_we = ctl.wr;
      flag_upd  = ctl.mask;
      flag_n    = ctl.mask[FLG_N] & result[DATA_W-1];
      flag_z    = ctl.mask[FLG_Z] & (result == '0);
      flag_c    = ctl.mask[FLG_C] ? add_c : carry_in;
      flag_v    = ctl.mask[FLG_V] & add_v;
   end

endmodule

// File: rtl/alu32_chk.sv
module alu32_chk #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8
) (
   input logic [3:0]        op_sel,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [IMM_W-1:0]  imm8,
   input logic              carry_in,
   input logic [DATA_W-1:0] result,
   input logic              result_we,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_c,
   input logic              flag_v,
   input logic [3:0]        flag_upd
);

   logic [DATA_W:0] plain_sum;
   assign plain_sum = {1'b0, opnd_a} + {1'b0, opnd_b};

   always_comb begin
      if (flag_upd[3])
         AST_N_FOLLOWS_MSB: assert (flag_n == result[DATA_W-1]) else $error("N mismatch"); // R1
      if (flag_upd[2])
         AST_Z_ON_ZERO: assert (flag_z == (result == '0)) else $error("Z mismatch"); // R1
      if (op_sel == 4'd0)
         AST_ADD_CARRY_OUT: assert (flag_c == plain_sum[DATA_W]) else $error("add C"); // R2
      if (op_sel == 4'd1 || op_sel == 4'd5)
         AST_SUB_NO_BORROW: assert (flag_c == (opnd_a >= opnd_b)) else $error("sub C"); // R3
      if (op_sel == 4'd4)
         AST_NEG_CARRY: assert (flag_c == (opnd_b == '0)) else $error("neg C"); // R3
      if (op_sel == 4'd5 || op_sel == 4'd6 || op_sel == 4'd7)
         AST_CMP_NO_WRITE: assert (!result_we) else $error("compare wrote"); // R6
      if (op_sel >= 4'd8 && op_sel <= 4'd14)
         AST_LOGIC_NZ_ONLY: assert (flag_upd == 4'b1100 && result_we) else $error("logic mask"); // R7
      if (op_sel == 4'd14)
         AST_MOVI_ZERO_EXT: assert (result == DATA_W'(imm8)) else $error("movi"); // R8
      if (op_sel == 4'd15)
         AST_UNDEF_QUIET: assert (result == '0 && !result_we && flag_upd == 4'b0000) else $error("undef"); // R9
      if (!flag_upd[1])
         AST_C_PASSTHRU: assert (flag_c == carry_in) else $error("C held"); // R10
      if (!flag_upd[0])
         AST_V_MASKED_ZERO: assert (!flag_v) else $error("V masked"); // R10
   end

endmodule

bind alu32_core alu32_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
   .op_sel    (op_sel),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .imm8      (imm8),
   .carry_in  (carry_in),
   .result    (result),
   .result_we (result_we),
   .flag_n    (flag_n),
   .flag_z    (flag_z),
   .flag_c    (flag_c),
   .flag_v    (flag_v),
   .flag_upd  (flag_upd)
);

// File: tb/alu32_core_tb.sv
module alu32_core_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 27;

   typedef struct packed {
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [7:0]  imm;
      logic        cin;
      logic [31:0] res;
      logic        we;
      logic [3:0]  flg;   // {N,Z,C,V}
      logic [3:0]  msk;
      logic [7:0]  req;
   } vec_t;

   // op, a, b, imm, cin, result, we, flags, mask, requirement
   localparam vec_t VECS [NVEC] = '{
      '{4'd0,  32'h00000001, 32'h00000002, 8'h00, 1'b1, 32'h00000003, 1'b1, 4'b0000, 4'hF, 8'd2}, // R2 carry_in ignored
      '{4'd0,  32'hFFFFFFFF, 32'h00000001, 8'h00, 1'b0, 32'h00000000, 1'b1, 4'b0110, 4'hF, 8'd2}, // R2 carry out, R1 zero
      '{4'd0,  32'h7FFFFFFF, 32'h00000001, 8'h00, 1'b0, 32'h80000000, 1'b1, 4'b1001, 4'hF, 8'd2}, // R2 overflow
      '{4'd1,  32'h00000005, 32'h00000003, 8'h00, 1'b0, 32'h00000002, 1'b1, 4'b0010, 4'hF, 8'd3}, // R3
      '{4'd1,  32'h00000003, 32'h00000005, 8'h00, 1'b1, 32'hFFFFFFFE, 1'b1, 4'b1000, 4'hF, 8'd3}, // R3 borrow
      '{4'd1,  32'h80000000, 32'h00000001, 8'h00, 1'b0, 32'h7FFFFFFF, 1'b1, 4'b0011, 4'hF, 8'd3}, // R3 overflow
      '{4'd2,  32'hFFFFFFFF, 32'h00000000, 8'h00, 1'b1, 32'h00000000, 1'b1, 4'b0110, 4'hF, 8'd4}, // R4
      '{4'd2,  32'h00000001, 32'h00000001, 8'h00, 1'b1, 32'h00000003, 1'b1, 4'b0000, 4'hF, 8'd4}, // R4
      '{4'd3,  32'h00000005, 32'h00000003, 8'h00, 1'b1, 32'h00000002, 1'b1, 4'b0010, 4'hF, 8'd5}, // R5
      '{4'd3,  32'h00000005, 32'h00000003, 8'h00, 1'b0, 32'h00000001, 1'b1, 4'b0010, 4'hF, 8'd5}, // R5
      '{4'd3,  32'h00000000, 32'hFFFFFFFF, 8'h00, 1'b0, 32'h00000000, 1'b1, 4'b0110, 4'hF, 8'd5}, // R5 B' wraps
      '{4'd4,  32'h00001234, 32'h00000001, 8'h00, 1'b0, 32'hFFFFFFFF, 1'b1, 4'b1000, 4'hF, 8'd3}, // R3 negate
      '{4'd4,  32'h0000FFFF, 32'h00000000, 8'h00, 1'b0, 32'h00000000, 1'b1, 4'b0110, 4'hF, 8'd3}, // R3 negate zero
      '{4'd4,  32'h00000000, 32'h80000000, 8'h00, 1'b0, 32'h80000000, 1'b1, 4'b1001, 4'hF, 8'd3}, // R3 negate min
      '{4'd5,  32'h00000007, 32'h00000007, 8'h00, 1'b0, 32'h00000000, 1'b0, 4'b0110, 4'hF, 8'd6}, // R6
      '{4'd6,  32'hFFFFFFFF, 32'h00000001, 8'h00, 1'b0, 32'h00000000, 1'b0, 4'b0110, 4'hF, 8'd6}, // R6
      '{4'd7,  32'h000000F0, 32'h0000000F, 8'h00, 1'b1, 32'h00000000, 1'b0, 4'b0110, 4'hC, 8'd6}, // R6, R10
      '{4'd8,  32'hFF00FF00, 32'h0F0F0F0F, 8'h00, 1'b0, 32'h0F000F00, 1'b1, 4'b0000, 4'hC, 8'd7}, // R7
      '{4'd9,  32'hFFFFFFFF, 32'h7FFFFFFF, 8'h00, 1'b1, 32'h80000000, 1'b1, 4'b1010, 4'hC, 8'd7}, // R7, R10
      '{4'd10, 32'h00000000, 32'h00000000, 8'h00, 1'b0, 32'h00000000, 1'b1, 4'b0100, 4'hC, 8'd7}, // R7
      '{4'd11, 32'hFFFFFFFF, 32'h0000FFFF, 8'h00, 1'b0, 32'hFFFF0000, 1'b1, 4'b1000, 4'hC, 8'd7}, // R7
      '{4'd12, 32'h12345678, 32'h00000000, 8'h00, 1'b0, 32'hFFFFFFFF, 1'b1, 4'b1000, 4'hC, 8'd7}, // R7
      '{4'd13, 32'h00010000, 32'h00010000, 8'h00, 1'b0, 32'h00000000, 1'b1, 4'b0100, 4'hC, 8'd8}, // R8
      '{4'd13, 32'h00000003, 32'hFFFFFFFF, 8'h00, 1'b0, 32'hFFFFFFFD, 1'b1, 4'b1000, 4'hC, 8'd8}, // R8
      '{4'd14, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'hFF, 1'b1, 32'h000000FF, 1'b1, 4'b0010, 4'hC, 8'd8}, // R8, R10
      '{4'd14, 32'h00000000, 32'h00000000, 8'h00, 1'b0, 32'h00000000, 1'b1, 4'b0100, 4'hC, 8'd8}, // R8
      '{4'd15, 32'h00000001, 32'h00000001, 8'hAB, 1'b1, 32'h00000000, 1'b0, 4'b0010, 4'h0, 8'd9}  // R9, R10
   };

   logic        clk = 1'b0;
   logic [3:0]  op_sel = 4'd15;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic [7:0]  imm8 = '0;
   logic        carry_in = 1'b0;
   logic [31:0] result;
   logic        result_we;
   logic        flag_n, flag_z, flag_c, flag_v;
   logic [3:0]  flag_upd;

   int applied = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu32_core dut_i (
      .op_sel    (op_sel),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .imm8      (imm8),
      .carry_in  (carry_in),
      .result    (result),
      .result_we (result_we),
      .flag_n    (flag_n),
      .flag_z    (flag_z),
      .flag_c    (flag_c),
      .flag_v    (flag_v),
      .flag_upd  (flag_upd)
   );

   task automatic apply(input vec_t v);
      logic [37:0] got, exp;
      @(posedge clk);
      op_sel   = v.op;
      opnd_a   = v.a;
      opnd_b   = v.b;
      imm8     = v.imm;
      carry_in = v.cin;
      @(negedge clk);
      applied++;
      got = {result, result_we, flag_n, flag_z, flag_c, flag_v, flag_upd[3]};
      exp = {v.res, v.we, v.flg, v.msk[3]};
      if (got != exp || flag_upd != v.msk) begin
         errors++;
         $display("FAIL R%0d op=%0d res/we/nzcv=%h/%b/%b%b%b%b mask=%b expected %h/%b/%b mask=%b",
                  v.req, v.op, result, result_we, flag_n, flag_z, flag_c, flag_v, flag_upd,
                  v.res, v.we, v.flg, v.msk);
      end
   endtask

   initial begin
      // reset-state check: undefined select at start is quiet (R9)
      @(negedge clk);
      applied++;
      if (result != 32'h0 || result_we || flag_upd != 4'h0) begin
         errors++;
         $display("FAIL R9 initial res=%h we=%b mask=%b expected 0/0/0", result, result_we, flag_upd);
      end

      for (int i = 0; i < NVEC; i++) apply(VECS[i]);

      // R5 directed: fold raises B' to 1, subtraction overflows
      apply('{4'd3, 32'h80000000, 32'h00000000, 8'h00, 1'b0, 32'h7FFFFFFF, 1'b1, 4'b0011, 4'hF, 8'd5});
      // R4 directed: carry-in alone pushes into overflow
      apply('{4'd2, 32'h7FFFFFFF, 32'h00000000, 8'h00, 1'b1, 32'h80000000, 1'b1, 4'b1001, 4'hF, 8'd4});

      // R6 / R9 sweep: write-enable across every select
      for (int s = 0; s < 16; s++) begin
         logic exp_we;
         @(posedge clk);
         op_sel = 4'(s); opnd_a = '0; opnd_b = '0; imm8 = '0; carry_in = 1'b0;
         @(negedge clk);
         exp_we = !(s == 5 || s == 6 || s == 7 || s == 15);
         applied++;
         if (result_we != exp_we) begin
            errors++;
            $display("FAIL R6 sweep op=%0d we=%b expected %b", s, result_we, exp_we);
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired, got hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
         $finish;
      end
   end

endmodule